// File: doc/BRIEF.md
# HDLC Frame Receiver with Control-Field Classifier

This block takes the serial receive line of a bit-synchronous link and turns it into whole octets for a link-layer controller. One bit is sampled on each rising edge of `clk`, which is the receive bit clock. Sampling happens only while `carrier` is high. The receiver hunts for the 0x7E flag, deletes the zero that the sender inserts after every run of five ones, and packs the remaining bits into octets, least significant bit first. While the frame arrives it runs the 16-bit frame check sequence over every octet.

Each frame ends at a closing flag, at an abort (a run of seven ones) or at the loss of carrier. At that point the block reports one end-of-frame event. The event carries a class decoded from the control octet, the send and receive sequence numbers, an exchange-identification marker, and a set of error flags. The flags cover a bad check sequence, a frame too short to be valid, a frame that does not end on an octet boundary, an abort, and an information field longer than the programmable limit `max_info`. The address, control and information octets go out on a byte stream with first and last markers. The two check-sequence octets are never delivered.

Top module: `hdlc_frame_receiver`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `byte_valid`, `byte_sof`, `byte_eof` and `frm_end` are low, every error output is low, `frm_xid`, `frm_ns` and `frm_nr` are zero, and `frm_type` is 3 (no class).
- R2: Frames are delimited by the flag octet 0x7E. Back-to-back flags that carry no complete octet between them produce no `frm_end`.
- R3: A zero received right after five consecutive ones is dropped. Octets such as 0x7E and 0xFF inside a frame are delivered unchanged.
- R4: Octets are assembled least significant bit first. All octets except the last two (the FCS) are delivered in order on `byte_valid`/`byte_data`. `byte_sof` marks the first delivered octet. `byte_eof` marks the last one and falls in the same cycle as `frm_end`. Two delivered octets are never in adjacent cycles.
- R5: The FCS is CRC-16 with polynomial x^16+x^12+x^5+1, bit-reflected, preset to 0xFFFF, and sent complemented with its low octet first. A frame whose running remainder after all octets is not 0xF0B8 sets `err_crc`.
- R6: `err_long` is set when the information field, meaning the total octet count minus 4, is larger than `max_info`. A field of exactly `max_info` octets passes.
- R7: `frm_type` is decoded from the second octet c. It is 0 (information) when c[0]=0, 1 (supervisory) when c[1:0]=01, and 2 (unnumbered) when c[1:0]=11. `frm_ns` is c[3:1] for information frames and 0 otherwise. `frm_nr` is c[7:5] for information and supervisory frames and 0 for unnumbered ones.
- R8: `frm_xid` is set exactly when the frame is unnumbered and c with bit 4 cleared equals 0xAF.
- R9: Seven consecutive ones end a frame that holds at least one octet. The result is `frm_end` with `err_abort` and `frm_type`=3, and no `byte_eof`. Bits are then ignored until the next flag.
- R10: A frame of one to three octets sets `err_short`.
- R11: A frame whose bit count between flags, after zero deletion, is not a multiple of eight sets `err_align`.
- R12: While `carrier` is low, the line is ignored. A fall of `carrier` inside a frame ends it as an abort (R9). After carrier returns, a flag is needed before a new frame starts.
- R13: At most one of `err_abort`, `err_align`, `err_short` and `err_crc` is set, taken in that order of precedence. `err_long` is reported only when abort, align and short are all clear. It can appear together with `err_crc`. All status outputs hold their value between `frm_end` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive bit clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Serial receive data |
| carrier | input | 1 | Carrier present; qualifies reception |
| max_info | input | N1_W | Largest information field accepted, in octets |
| byte_valid | output | 1 | Delivered octet strobe |
| byte_data | output | 8 | Delivered octet |
| byte_sof | output | 1 | First octet of a frame |
| byte_eof | output | 1 | Last delivered octet of a frame |
| frm_end | output | 1 | End-of-frame event; status below is updated |
| frm_type | output | 2 | Frame class: 0 info, 1 supervisory, 2 unnumbered, 3 none |
| frm_xid | output | 1 | Exchange-identification frame |
| frm_ns | output | 3 | Send sequence number |
| frm_nr | output | 3 | Receive sequence number |
| err_abort | output | 1 | Frame ended by abort or carrier loss |
| err_align | output | 1 | Frame not a whole number of octets |
| err_short | output | 1 | Fewer than four octets |
| err_crc | output | 1 | Check sequence mismatch |
| err_long | output | 1 | Information field above `max_info` |

## Verification
The length-limit check and the check-sequence check are both settled by the same closing flag, so both verdicts land on the same `frm_end`. The bench provokes this with frames whose information field is longer than `max_info` and which also carry a flipped bit. It expects `err_long` and `err_crc` to rise together, while the precedence rule keeps the other three flags low. A second collision case is an abort that hits a frame already too short: the bench expects only `err_abort`.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

  typedef enum logic [1:0] {
    FT_INFO  = 2'd0,
    FT_SUPV  = 2'd1,
    FT_UNNUM = 2'd2,
    FT_NONE  = 2'd3
  } frame_kind_e;

  localparam logic [15:0] FCS_PRESET  = 16'hFFFF;
  localparam logic [15:0] FCS_RESIDUE = 16'hF0B8;
  localparam logic [15:0] FCS_POLY_R  = 16'h8408;

  // one octet of the reflected CRC, bit 0 first
  function automatic logic [15:0] fcs_octet(input logic [15:0] cur, input logic [7:0] oct);
    logic [15:0] r;
    r = cur;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ oct[i]) r = (r >> 1) ^ FCS_POLY_R;
      else               r = r >> 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/hdlc_bit_destuff.sv
module hdlc_bit_destuff #(
  parameter int RUN_W = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic rxd,
  input  logic carrier,
  output logic bit_v,
  output logic bit_d,
  output logic flag_p,
  output logic abort_p
);
  localparam logic [RUN_W-1:0] RUN_STUFF = RUN_W'(5);
  localparam logic [RUN_W-1:0] RUN_FLAG  = RUN_W'(6);
  localparam logic [RUN_W-1:0] RUN_SAT   = '1;

  logic [RUN_W-1:0] run;
  logic             car_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run     <= '0;
      car_q   <= 1'b0;
      bit_v   <= 1'b0;
      bit_d   <= 1'b0;
      flag_p  <= 1'b0;
      abort_p <= 1'b0;
    end else begin
      car_q   <= carrier;
      bit_v   <= 1'b0;
      flag_p  <= 1'b0;
      abort_p <= 1'b0;
      bit_d   <= rxd;
      if (!carrier) begin
        run     <= '0;
        abort_p <= car_q;
      end else if (rxd) begin
        if (run != RUN_SAT) run <= run + 1'b1;
        if (run == RUN_FLAG)      abort_p <= 1'b1;
        else if (run < RUN_STUFF) bit_v   <= 1'b1;
      end else begin
        run <= '0;
        if (run == RUN_FLAG)      flag_p <= 1'b1;
        else if (run < RUN_STUFF) bit_v  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/hdlc_octet_framer.sv
module hdlc_octet_framer #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_v,
  input  logic             bit_d,
  input  logic             flag_p,
  input  logic             abort_p,
  output logic             oct_v,
  output logic [7:0]       oct_d,
  output logic             sync_p,
  output logic             end_v,
  output logic             end_abort,
  output logic             end_misalign,
  output logic [CNT_W-1:0] end_cnt
);
  localparam logic [CNT_W-1:0] CNT_SAT   = '1;
  localparam logic [2:0]       FLAG_TAIL = 3'd6;

  logic             hunting;
  logic [7:0]       sh;
  logic [2:0]       bpos;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      hunting      <= 1'b1;
      sh           <= '0;
      bpos         <= '0;
      cnt          <= '0;
      oct_v        <= 1'b0;
      oct_d        <= '0;
      sync_p       <= 1'b0;
      end_v        <= 1'b0;
      end_abort    <= 1'b0;
      end_misalign <= 1'b0;
      end_cnt      <= '0;
    end else begin
      oct_v  <= 1'b0;
      sync_p <= 1'b0;
      end_v  <= 1'b0;
      if (flag_p || abort_p) begin
        sync_p <= 1'b1;
        if (!hunting && cnt != '0) begin
          end_v        <= 1'b1;
          end_abort    <= abort_p;
          end_misalign <= (bpos != FLAG_TAIL);
          end_cnt      <= cnt;
        end
        hunting <= abort_p;
        bpos    <= '0;
        cnt     <= '0;
      end else if (bit_v && !hunting) begin
        sh   <= {bit_d, sh[7:1]};
        bpos <= bpos + 1'b1;
        if (bpos == 3'd7) begin
          oct_v <= 1'b1;
          oct_d <= {bit_d, sh[7:1]};
          if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/hdlc_fcs_check.sv
module hdlc_fcs_check
  import hdlc_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       clear,
  input  logic       oct_v,
  input  logic [7:0] oct_d,
  output logic       fcs_ok
);
  logic [15:0] rem;

  always_ff @(posedge clk) begin
    if (rst || clear)  rem <= FCS_PRESET;
    else if (oct_v)    rem <= fcs_octet(rem, oct_d);
  end

  assign fcs_ok = (rem == FCS_RESIDUE);
endmodule

// File: rtl/hdlc_ctrl_decode.sv
module hdlc_ctrl_decode
  import hdlc_rx_pkg::*;
(
  input  logic [7:0]  ctrl,
  output frame_kind_e kind,
  output logic [2:0]  ns,
  output logic [2:0]  nr,
  output logic        xid
);
  localparam logic [7:0] PF_MASK  = 8'hEF;
  localparam logic [7:0] XID_CODE = 8'hAF;

  always_comb begin
    if (!ctrl[0])     kind = FT_INFO;
    else if (!ctrl[1]) kind = FT_SUPV;
    else              kind = FT_UNNUM;
    ns  = (kind == FT_INFO)  ? ctrl[3:1] : 3'd0;
    nr  = (kind == FT_UNNUM) ? 3'd0 : ctrl[7:5];
    xid = (kind == FT_UNNUM) && ((ctrl & PF_MASK) == XID_CODE);
  end
endmodule

// File: rtl/hdlc_frame_receiver.sv
module hdlc_frame_receiver
  import hdlc_rx_pkg::*;
#(
  parameter int N1_W = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rxd,
  input  logic            carrier,
  input  logic [N1_W-1:0] max_info,
  output logic            byte_valid,
  output logic [7:0]      byte_data,
  output logic            byte_sof,
  output logic            byte_eof,
  output logic            frm_end,
  output logic [1:0]      frm_type,
  output logic            frm_xid,
  output logic [2:0]      frm_ns,
  output logic [2:0]      frm_nr,
  output logic            err_abort,
  output logic            err_align,
  output logic            err_short,
  output logic            err_crc,
  output logic            err_long
);
  localparam int CNT_W    = N1_W + 2;
  localparam int OVERHEAD = 4;
  localparam int HOLD     = 3;
  localparam int HC_W     = $clog2(HOLD + 1);
  localparam logic [HC_W-1:0] HC_FULL = HC_W'(HOLD);
  localparam logic [HC_W-1:0] HC_CTRL = HC_W'(1);

  logic             bit_v, bit_d, flag_p, abort_p;
  logic             oct_v, sync_p, end_v, end_abort, end_misalign;
  logic [7:0]       oct_d;
  logic [CNT_W-1:0] end_cnt;
  logic             fcs_ok;

  hdlc_bit_destuff #(.RUN_W(3)) u_destuff (
    .clk(clk), .rst(rst), .rxd(rxd), .carrier(carrier),
    .bit_v(bit_v), .bit_d(bit_d), .flag_p(flag_p), .abort_p(abort_p)
  );

  hdlc_octet_framer #(.CNT_W(CNT_W)) u_framer (
    .clk(clk), .rst(rst), .bit_v(bit_v), .bit_d(bit_d),
    .flag_p(flag_p), .abort_p(abort_p),
    .oct_v(oct_v), .oct_d(oct_d), .sync_p(sync_p),
    .end_v(end_v), .end_abort(end_abort), .end_misalign(end_misalign),
    .end_cnt(end_cnt)
  );

  hdlc_fcs_check u_fcs (
    .clk(clk), .rst(rst), .clear(sync_p),
    .oct_v(oct_v), .oct_d(oct_d), .fcs_ok(fcs_ok)
  );

  logic [7:0]       ctrl_q;
  logic             ctrl_seen;
  frame_kind_e      dec_kind;
  logic [2:0]       dec_ns, dec_nr;
  logic             dec_xid;

  hdlc_ctrl_decode u_decode (
    .ctrl(ctrl_q), .kind(dec_kind), .ns(dec_ns), .nr(dec_nr), .xid(dec_xid)
  );

  // three-octet delay line keeps the FCS off the byte stream
  logic [7:0]       hold [HOLD];
  logic [HC_W-1:0]  hcnt;
  logic             sent_any;

  logic short_w, long_w, keep_w;
  assign short_w = (end_cnt < CNT_W'(OVERHEAD));
  assign long_w  = (end_cnt > (CNT_W'(max_info) + CNT_W'(OVERHEAD)));
  assign keep_w  = !end_abort && ctrl_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < HOLD; i++) hold[i] <= '0;
      hcnt       <= '0;
      sent_any   <= 1'b0;
      ctrl_q     <= '0;
      ctrl_seen  <= 1'b0;
      byte_valid <= 1'b0;
      byte_data  <= '0;
      byte_sof   <= 1'b0;
      byte_eof   <= 1'b0;
      frm_end    <= 1'b0;
      frm_type   <= FT_NONE;
      frm_xid    <= 1'b0;
      frm_ns     <= '0;
      frm_nr     <= '0;
      err_abort  <= 1'b0;
      err_align  <= 1'b0;
      err_short  <= 1'b0;
      err_crc    <= 1'b0;
      err_long   <= 1'b0;
    end else begin
      byte_valid <= 1'b0;
      byte_sof   <= 1'b0;
      byte_eof   <= 1'b0;
      frm_end    <= 1'b0;
      if (end_v) begin
        frm_end <= 1'b1;
        if (!end_abort && hcnt == HC_FULL) begin
          byte_valid <= 1'b1;
          byte_data  <= hold[HOLD-1];
          byte_sof   <= !sent_any;
          byte_eof   <= 1'b1;
        end
        err_abort <= end_abort;
        err_align <= !end_abort && end_misalign;
        err_short <= !end_abort && !end_misalign && short_w;
        err_crc   <= !end_abort && !end_misalign && !short_w && !fcs_ok;
        err_long  <= !end_abort && !end_misalign && !short_w && long_w;
        frm_type  <= keep_w ? dec_kind : FT_NONE;
        frm_xid   <= keep_w && dec_xid;
        frm_ns    <= keep_w ? dec_ns : 3'd0;
        frm_nr    <= keep_w ? dec_nr : 3'd0;
      end else if (oct_v) begin
        for (int i = HOLD - 1; i > 0; i--) hold[i] <= hold[i-1];
        hold[0] <= oct_d;
        if (hcnt == HC_FULL) begin
          byte_valid <= 1'b1;
          byte_data  <= hold[HOLD-1];
          byte_sof   <= !sent_any;
          sent_any   <= 1'b1;
        end else begin
          hcnt <= hcnt + 1'b1;
        end
        if (hcnt == HC_CTRL) begin
          ctrl_q    <= oct_d;
          ctrl_seen <= 1'b1;
        end
      end
      if (sync_p) begin
        hcnt      <= '0;
        sent_any  <= 1'b0;
        ctrl_seen <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/hdlc_rx_checker.sv
module hdlc_rx_checker (
  input logic       clk,
  input logic       rst,
  input logic       byte_valid,
  input logic       byte_sof,
  input logic       byte_eof,
  input logic       frm_end,
  input logic [1:0] frm_type,
  input logic       frm_xid,
  input logic [2:0] frm_ns,
  input logic [2:0] frm_nr,
  input logic       err_abort,
  input logic       err_align,
  input logic       err_short,
  input logic       err_crc,
  input logic       err_long
);
  // R4
  last_with_end_chk: assert property (@(posedge clk) disable iff (rst)
    byte_eof |-> (frm_end && byte_valid));

  // R4
  first_is_valid_chk: assert property (@(posedge clk) disable iff (rst)
    byte_sof |-> byte_valid);

  // R4
  octet_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    byte_valid |=> !byte_valid);

  // R13
  error_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({err_abort, err_align, err_short, err_crc}));

  // R13
  status_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !frm_end |-> $stable({frm_type, frm_xid, frm_ns, frm_nr,
                          err_abort, err_align, err_short, err_crc, err_long}));

  // R9
  abort_no_last_chk: assert property (@(posedge clk) disable iff (rst)
    (frm_end && err_abort) |-> (!byte_eof && frm_type == 2'd3));

  // R8
  xid_unnumbered_chk: assert property (@(posedge clk) disable iff (rst)
    frm_xid |-> (frm_type == 2'd2));

  // R7
  unnum_no_seq_chk: assert property (@(posedge clk) disable iff (rst)
    (frm_type == 2'd2) |-> (frm_ns == 3'd0 && frm_nr == 3'd0));

  // R13
  long_needs_clean_chk: assert property (@(posedge clk) disable iff (rst)
    err_long |-> !(err_abort || err_align || err_short));
endmodule

bind hdlc_frame_receiver hdlc_rx_checker u_rx_checker (
  .clk(clk), .rst(rst), .byte_valid(byte_valid), .byte_sof(byte_sof),
  .byte_eof(byte_eof), .frm_end(frm_end), .frm_type(frm_type),
  .frm_xid(frm_xid), .frm_ns(frm_ns), .frm_nr(frm_nr),
  .err_abort(err_abort), .err_align(err_align), .err_short(err_short),
  .err_crc(err_crc), .err_long(err_long)
);

// File: tb/test_hdlc_frame_receiver.sv
`timescale 1ns/1ps
module test_hdlc_frame_receiver;
  localparam int N1_W = 12;

  logic clk = 1'b0, rst = 1'b1, rxd = 1'b1, carrier = 1'b0;
  logic [N1_W-1:0] max_info = 12'd3;
  logic byte_valid, byte_sof, byte_eof, frm_end, frm_xid;
  logic [7:0] byte_data;
  logic [1:0] frm_type;
  logic [2:0] frm_ns, frm_nr;
  logic err_abort, err_align, err_short, err_crc, err_long;

  hdlc_frame_receiver #(.N1_W(N1_W)) i_hdlc_frame_receiver (
    .clk(clk), .rst(rst), .rxd(rxd), .carrier(carrier), .max_info(max_info),
    .byte_valid(byte_valid), .byte_data(byte_data), .byte_sof(byte_sof),
    .byte_eof(byte_eof), .frm_end(frm_end), .frm_type(frm_type), .frm_xid(frm_xid),
    .frm_ns(frm_ns), .frm_nr(frm_nr), .err_abort(err_abort), .err_align(err_align),
    .err_short(err_short), .err_crc(err_crc), .err_long(err_long)
  );

  always #2 clk = ~clk;

  int checks = 0, errors = 0, ones = 0;
  bit done = 0;

  // monitor, sampled away from the active edge
  logic [7:0] rx_buf [0:63];
  int rx_n = 0, ev_n = 0, eof_n = 0, sof_bad = 0;
  logic [1:0] s_type; logic s_xid; logic [2:0] s_ns, s_nr;
  logic s_ab, s_al, s_sh, s_crc, s_lg;

  always @(negedge clk) begin
    if (!rst) begin
      if (byte_valid) begin
        if (rx_n < 64) rx_buf[rx_n] = byte_data;
        if (byte_sof != (rx_n == 0)) sof_bad++;
        if (byte_eof) eof_n++;
        rx_n++;
      end
      if (frm_end) begin
        ev_n++;
        s_type = frm_type; s_xid = frm_xid; s_ns = frm_ns; s_nr = frm_nr;
        s_ab = err_abort; s_al = err_align; s_sh = err_short; s_crc = err_crc; s_lg = err_long;
      end
    end
  end

  logic [7:0] tx [0:63];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic send_raw(input logic b);
    @(negedge clk); rxd = b;
  endtask

  task automatic send_data_bit(input logic b);
    send_raw(b);
    if (b) begin
      ones++;
      if (ones == 5) begin send_raw(1'b0); ones = 0; end
    end else ones = 0;
  endtask

  task automatic send_flag();
    for (int i = 0; i < 8; i++) send_raw(i != 0 && i != 7);
    ones = 0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) send_data_bit(b[i]);
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(negedge clk); rxd = 1'b1; end
    ones = 0;
    @(posedge clk);
  endtask

  task automatic clear_mon();
    @(posedge clk);
    rx_n = 0; ev_n = 0; eof_n = 0; sof_bad = 0;
  endtask

  function automatic logic [15:0] ref_crc(input int n);
    logic [15:0] c = 16'hFFFF;
    for (int k = 0; k < n; k++)
      for (int i = 0; i < 8; i++)
        c = (c[0] ^ tx[k][i]) ? ((c >> 1) ^ 16'h8408) : (c >> 1);
    return c;
  endfunction

  task automatic send_frame(input int n, input bit add_fcs, input int flip, input int zeros);
    int tot;
    logic [15:0] f;
    tot = n;
    if (add_fcs) begin
      f = ~ref_crc(n);
      tx[n] = f[7:0]; tx[n+1] = f[15:8]; tot = n + 2;
    end
    if (flip >= 0) tx[flip/8][flip%8] = ~tx[flip/8][flip%8];
    send_flag();
    for (int i = 0; i < tot; i++) send_byte(tx[i]);
    repeat (zeros) send_data_bit(1'b0);
    send_flag();
  endtask

  task automatic check_status(input string req, input bit ab, input bit al, input bit sh,
                              input bit cr, input bit lg);
    chk(ev_n == 1, req, "frame events", ev_n, 1);
    chk(s_ab == ab, req, "err_abort", s_ab, ab);
    chk(s_al == al, req, "err_align", s_al, al);
    chk(s_sh == sh, req, "err_short", s_sh, sh);
    chk(s_crc == cr, req, "err_crc", s_crc, cr);
    chk(s_lg == lg, req, "err_long", s_lg, lg);
  endtask

  task automatic check_bytes(input string req, input int n);
    chk(rx_n == n, req, "octets delivered", rx_n, n);
    for (int i = 0; i < n && i < rx_n; i++)
      chk(rx_buf[i] == tx[i], req, "octet value", rx_buf[i], tx[i]);
    chk(eof_n == (n > 0 ? 1 : 0), req, "last marker count", eof_n, (n > 0 ? 1 : 0));
    chk(sof_bad == 0, req, "first marker placement", sof_bad, 0);
  endtask

  task automatic good_frame(input int n);
    idle(4); clear_mon(); send_frame(n, 1'b1, -1, 0); idle(12);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    // R1 reset state
    chk(byte_valid == 0 && frm_end == 0 && byte_eof == 0 && byte_sof == 0, "R1", "strobes", frm_end, 0);
    chk(frm_type == 2'd3, "R1", "frm_type", frm_type, 3);
    chk({err_abort, err_align, err_short, err_crc, err_long, frm_xid, frm_ns, frm_nr} == 0,
        "R1", "status", err_crc, 0);

    // R2 idle ones and back-to-back flags give no frame
    carrier = 1'b1;
    idle(20); clear_mon();
    repeat (4) send_flag();
    idle(12);
    chk(ev_n == 0, "R2", "events for bare flags", ev_n, 0);

    // R7 R8 sweep of every control octet
    for (int c = 0; c < 256; c++) begin
      logic [7:0] cb;
      int et, ens, enr;
      bit ex;
      cb = 8'(c);
      tx[0] = 8'h03; tx[1] = cb;
      good_frame(2);
      et  = !cb[0] ? 0 : (!cb[1] ? 1 : 2);
      ens = (et == 0) ? int'(cb[3:1]) : 0;
      enr = (et == 2) ? 0 : int'(cb[7:5]);
      ex  = (et == 2) && ((cb & 8'hEF) == 8'hAF);
      check_status("R5", 0, 0, 0, 0, 0);
      chk(s_type == et, "R7", "frm_type", s_type, et);
      chk(s_ns == ens, "R7", "frm_ns", s_ns, ens);
      chk(s_nr == enr, "R7", "frm_nr", s_nr, enr);
      chk(s_xid == ex, "R8", "frm_xid", s_xid, ex);
      check_bytes("R4", 2);
    end

    // R6 R3 length limit sweep with flag-like and all-ones payloads
    for (int lim = 0; lim < 4; lim++) begin
      max_info = 12'(lim);
      for (int len = 0; len < 7; len++) begin
        tx[0] = 8'hFF; tx[1] = 8'h10;
        for (int k = 0; k < len; k++) tx[2+k] = k[0] ? 8'hFF : (8'h7E ^ 8'(k));
        good_frame(2 + len);
        check_status("R6", 0, 0, 0, 0, len > lim);
        check_bytes("R3", 2 + len);
      end
    end

    // R13 over-length frame with a corrupted bit: both verdicts together
    max_info = 12'd1;
    for (int fb = 16; fb < 40; fb += 5) begin
      tx[0] = 8'h01; tx[1] = 8'h00; tx[2] = 8'h5A; tx[3] = 8'hC3; tx[4] = 8'h7E;
      idle(4); clear_mon(); send_frame(5, 1'b1, fb, 0); idle(12);
      check_status("R13", 0, 0, 0, 1, 1);
    end
    max_info = 12'd64;

    // R5 every single-bit corruption of a six-octet frame
    for (int fb = 0; fb < 48; fb++) begin
      tx[0] = 8'h03; tx[1] = 8'h22; tx[2] = 8'hF0; tx[3] = 8'h3F;
      idle(4); clear_mon(); send_frame(4, 1'b1, fb, 0); idle(12);
      check_status("R5", 0, 0, 0, 1, 0);
    end

    // R10 frames of one to three octets
    for (int n = 1; n < 4; n++) begin
      tx[0] = 8'h03; tx[1] = 8'h3F; tx[2] = 8'h99;
      idle(4); clear_mon(); send_frame(n, 1'b0, -1, 0); idle(12);
      check_status("R10", 0, 0, 1, 0, 0);
      check_bytes("R10", n == 3 ? 1 : 0);
    end

    // R11 extra bits before the closing flag
    for (int z = 1; z < 8; z++) begin
      tx[0] = 8'h03; tx[1] = 8'h11;
      idle(4); clear_mon(); send_frame(2, 1'b1, -1, z); idle(12);
      check_status("R11", 0, 1, 0, 0, 0);
    end

    // R9 abort mid-frame, then data without a flag is ignored
    idle(4); clear_mon();
    send_flag(); send_byte(8'h03); send_byte(8'h00); send_byte(8'h55); send_byte(8'hAA);
    repeat (8) send_raw(1'b1);
    idle(12);
    check_status("R9", 1, 0, 0, 0, 0);
    chk(eof_n == 0, "R9", "last marker after abort", eof_n, 0);
    chk(s_type == 2'd3, "R9", "frm_type after abort", s_type, 3);
    clear_mon();
    send_byte(8'h12); send_byte(8'h34); send_byte(8'h56);
    idle(12);
    chk(ev_n == 0 && rx_n == 0, "R9", "activity while hunting", ev_n + rx_n, 0);
    tx[0] = 8'h03; tx[1] = 8'h00;
    good_frame(2);
    check_status("R9", 0, 0, 0, 0, 0);

    // R13 abort of a one-octet frame reports only the abort
    idle(4); clear_mon();
    send_flag(); send_byte(8'h03);
    repeat (8) send_raw(1'b1);
    idle(12);
    check_status("R13", 1, 0, 0, 0, 0);

    // R12 carrier loss inside a frame, then a whole frame sent with no carrier
    idle(4); clear_mon();
    send_flag(); send_byte(8'h03); send_byte(8'h44); send_byte(8'h21);
    @(negedge clk); carrier = 1'b0;
    idle(6);
    check_status("R12", 1, 0, 0, 0, 0);
    clear_mon();
    tx[0] = 8'h03; tx[1] = 8'h00;
    send_frame(2, 1'b1, -1, 0);
    idle(12);
    chk(ev_n == 0 && rx_n == 0, "R12", "activity without carrier", ev_n + rx_n, 0);
    @(negedge clk); carrier = 1'b1;
    clear_mon();
    send_byte(8'h0F); send_byte(8'hF0);
    idle(12);
    chk(ev_n == 0, "R12", "frame without opening flag", ev_n, 0);
    tx[0] = 8'h07; tx[1] = 8'h2A;
    good_frame(2);
    check_status("R12", 0, 0, 0, 0, 0);
    check_bytes("R12", 2);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule